// File: doc/BRIEF.md
# Sectioned Vernier TDC Timestamp Merger

This block turns the latched tap snapshots of a sectioned Vernier delay line into time-to-digital timestamps. A free-running coarse counter advances once per reference clock period, and one period spans the full range of the fine line. The line is split into `NSEC` sections of `TAPS` taps each. Every section is read on its own progressively delayed clock. In this synchronous model, the snapshot that section `s` takes for a given period reaches the input `s` cycles after the snapshot of section 0 for that period. Within the concatenated line, tap 0 is the earliest tap of section 0, and section `s` occupies bits `[s*TAPS +: TAPS]` of the tap bus.

The block delays each section by `NSEC - s` register stages and the coarse value by `NSEC` stages. After this, all pieces of one period meet in the same cycle. The merged line then passes through a three-tap majority filter that removes bubbles. A priority search finds the first zero, which is where the start edge stopped. The resulting fine code is paired with the coarse count sampled alongside section 0. The period span is a power of two (64 taps by default), so the full timestamp is the concatenation `{coarse, fine}`, which equals coarse x span + fine.

Because the stages form a pipeline, snapshots of successive periods are in flight at the same time, and each period yields its own result. A two-state controller manages start-up. After reset it stays in state FILL for `NSEC` cycles, while the pipeline still carries pre-reset data. It then moves to state RUN (transition FILL->RUN, taken when the fill count reaches `NSEC-1`) and stays there until the next reset. Output is possible only in RUN.

Top module: `tdc_readout_pipe`

## Requirements
- R1: While reset is asserted and just after it, `stamp_valid_o`, `stamp_coarse_o` and `stamp_fine_o` are all 0.
- R2: The coarse counter starts at 0 on the first clock edge after reset, advances by one on every edge, and wraps from 2^COARSE_W-1 to 0.
- R3: Section `s`'s snapshot for a period is taken from the tap bus exactly `s` cycles after section 0's snapshot for the same period, and both are merged into one result.
- R4: The fine code is the index of the first 0 in the filtered line, counted from tap 0. A virtual 1 sits before tap 0, so an all-zero line gives fine 0. The largest fine code is NSEC*TAPS-1.
- R5: Before the search, each tap is replaced by the majority of itself and its two neighbours. The neighbour before tap 0 counts as 1 and the neighbour after the last tap counts as 0. As a result, a single flipped bit at least two taps away from the true transition does not change the fine code.
- R6: A period whose filtered line holds no 0 (all taps set, meaning no stop) produces no valid output.
- R7: If section 0's snapshot for a period is sampled at edge E, the result appears on the outputs after edge E+NSEC, with `stamp_valid_o` high for that one cycle only.
- R8: The coarse field of a result equals the counter value sampled at edge E, the same edge at which section 0's snapshot was taken. This holds across counter wrap-around.
- R9: Stops in consecutive periods each produce their own result on consecutive cycles, with no result lost or merged.
- R10: In state FILL, which lasts the first NSEC edges after reset, no valid output is produced, whatever the tap bus holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one period is the full fine range |
| rst_n | input | 1 | Active-low synchronous reset |
| taps_i | input | NSEC*TAPS (64) | Section snapshots; section s at bits [s*TAPS +: TAPS], skewed by s cycles |
| stamp_valid_o | output | 1 | One-cycle strobe marking a new timestamp |
| stamp_coarse_o | output | COARSE_W (16) | Coarse count of the period that held the stop |
| stamp_fine_o | output | FINE_W (6) | Position of the stop within the period |

## Verification
The assertions assume that the tap bus follows the skew discipline: the value of each section at any edge belongs to the period that section 0 presented `s` edges earlier. They also assume that an all-ones line means "no stop". To keep within this, the stimulus stores one full-line pattern per period in a ring and drives every section from the entry of its own period. Pre-reset periods are driven as all-zero lines, so they can only be rejected by the FILL state. The sweep covers every fine position, single-bit bubbles on both sides of the transition, idle periods and a counter wrap. All expected values are derived from the thermometer length chosen for each period.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    // Start-up controller of the merge stage
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,   // pipeline still holds pre-reset snapshots
        ST_RUN  = 1'b1    // aligned data is trustworthy
    } merge_state_e;

    // Three-input majority vote used by the bubble filter
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tdc_delay_pipe.sv
module tdc_delay_pipe #(
    parameter int W        = 16,
    parameter int DEPTH    = 1,
    parameter bit RST_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

    logic [W-1:0] stage_q [DEPTH];

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_stage
            if (k == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[k] <= RST_VAL;
                    else        stage_q[k] <= stage_q[k-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
    parameter int COARSE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [COARSE_W-1:0] count_o
);
    logic [COARSE_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

    // R2: one step per reference period, modulo 2^COARSE_W
    p_coarse_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count_q == COARSE_W'($past(count_q) + 1'b1));

endmodule

// File: rtl/tdc_section_align.sv
module tdc_section_align #(
    parameter int NSEC     = 4,
    parameter int TAPS     = 16,
    parameter int COARSE_W = 16,
    localparam int LINE_W  = NSEC * TAPS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LINE_W-1:0]   taps_i,
    input  logic [COARSE_W-1:0] coarse_i,
    output logic [LINE_W-1:0]   line_o,
    output logic [COARSE_W-1:0] coarse_o
);
    // R3: section s arrives s cycles late, so it gets NSEC-s stages;
    // every piece of one period leaves the last stage after edge E+NSEC-1.
    generate
        for (genvar s = 0; s < NSEC; s++) begin : g_sec
            tdc_delay_pipe #(
                .W        (TAPS),
                .DEPTH    (NSEC - s),
                .RST_ONES (1'b1)
            ) u_sec_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (taps_i[s*TAPS +: TAPS]),
                .q_o   (line_o[s*TAPS +: TAPS])
            );
        end
    endgenerate

    // R8: coarse sampled on the same edge as section 0, same depth
    tdc_delay_pipe #(
        .W        (COARSE_W),
        .DEPTH    (NSEC),
        .RST_ONES (1'b0)
    ) u_coarse_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (coarse_i),
        .q_o   (coarse_o)
    );

endmodule

// File: rtl/tdc_fine_encoder.sv
module tdc_fine_encoder #(
    parameter int LINE_W  = 64,
    localparam int FINE_W = $clog2(LINE_W)
) (
    input  logic [LINE_W-1:0] line_i,
    output logic              found_o,
    output logic [FINE_W-1:0] fine_o
);
    import tdc_pkg::*;

    // Extended line: virtual 1 below tap 0, virtual 0 above the last tap (R5)
    logic [LINE_W+1:0] ext;
    logic [LINE_W-1:0] filt;

    assign ext = {1'b0, line_i, 1'b1};

    generate
        for (genvar i = 0; i < LINE_W; i++) begin : g_vote
            assign filt[i] = maj3(ext[i], ext[i+1], ext[i+2]);
        end
    endgenerate

    // R4: lowest zero wins
    always_comb begin
        fine_o = '0;
        for (int i = LINE_W - 1; i >= 0; i--) begin
            if (!filt[i]) fine_o = FINE_W'(i);
        end
    end

    // R6: nothing to report when the filtered line is all ones
    assign found_o = ~&filt;

endmodule

// File: rtl/tdc_readout_pipe.sv
module tdc_readout_pipe #(
    parameter int NSEC     = 4,
    parameter int TAPS     = 16,
    parameter int COARSE_W = 16,
    localparam int LINE_W  = NSEC * TAPS,
    localparam int FINE_W  = $clog2(LINE_W),
    localparam int FILL_W  = $clog2(NSEC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LINE_W-1:0]   taps_i,
    output logic                stamp_valid_o,
    output logic [COARSE_W-1:0] stamp_coarse_o,
    output logic [FINE_W-1:0]   stamp_fine_o
);
    import tdc_pkg::*;

    logic [COARSE_W-1:0] coarse_now;
    logic [COARSE_W-1:0] coarse_aln;
    logic [LINE_W-1:0]   line_aln;
    logic                enc_found;
    logic [FINE_W-1:0]   enc_fine;

    merge_state_e        state_q, state_d;
    logic [FILL_W-1:0]   fill_q;

    tdc_coarse_ctr #(
        .COARSE_W (COARSE_W)
    ) u_coarse (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (coarse_now)
    );

    tdc_section_align #(
        .NSEC     (NSEC),
        .TAPS     (TAPS),
        .COARSE_W (COARSE_W)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .taps_i   (taps_i),
        .coarse_i (coarse_now),
        .line_o   (line_aln),
        .coarse_o (coarse_aln)
    );

    tdc_fine_encoder #(
        .LINE_W (LINE_W)
    ) u_enc (
        .line_i  (line_aln),
        .found_o (enc_found),
        .fine_o  (enc_fine)
    );

    // Next-state logic: FILL -> RUN once NSEC edges have passed (R10)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (fill_q == FILL_W'(NSEC - 1)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    // State register and fill counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL) fill_q <= fill_q + 1'b1;
        end
    end

    // Output register: one strobe per period holding a stop (R7, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_valid_o  <= 1'b0;
            stamp_coarse_o <= '0;
            stamp_fine_o   <= '0;
        end else begin
            stamp_valid_o <= (state_q == ST_RUN) && enc_found;
            if ((state_q == ST_RUN) && enc_found) begin
                stamp_coarse_o <= coarse_aln;
                stamp_fine_o   <= enc_fine;
            end
        end
    end

    // R10: nothing leaves while the pipeline is still filling
    p_fill_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |=> !stamp_valid_o);

    // R6: an all-ones aligned line never yields a strobe
    p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&line_aln) |=> !stamp_valid_o);

    // R8: the coarse field trails the live counter by NSEC+1
    p_coarse_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid_o |-> stamp_coarse_o == COARSE_W'(coarse_now - COARSE_W'(NSEC + 1)));

    // R7: a strobe follows every stop found once running
    p_found_emits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && enc_found) |=> stamp_valid_o);

endmodule

// File: tb/tdc_readout_pipe_tb_top.sv
module tdc_readout_pipe_tb_top;
    localparam int NSEC  = 4;
    localparam int TAPS  = 16;
    localparam int N     = NSEC * TAPS;
    localparam int CW    = 16;
    localparam int FW    = 6;
    localparam int NLAST = 65546;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  taps = '0;
    logic          v;
    logic [CW-1:0] coarse;
    logic [FW-1:0] fine;

    int checks = 0;
    int fails  = 0;

    logic [N-1:0] pat_r  [8];
    int           fexp_r [8];
    int           kind_r [8];

    always #2.5 clk = ~clk;

    tdc_readout_pipe #(.NSEC(NSEC), .TAPS(TAPS), .COARSE_W(CW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .taps_i         (taps),
        .stamp_valid_o  (v),
        .stamp_coarse_o (coarse),
        .stamp_fine_o   (fine)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Period schedule: f = thermometer length (N means no stop), g = bubble bit
    function automatic void sched(input int n, output int f, output int g, output int kind);
        int k;
        f = N; g = -1; kind = 0;
        if (n >= 2 && n < 2 + N + 1) begin
            f = n - 2;                    // R4, R9: every position back to back
            kind = (f == N) ? 0 : 1;
        end else if (n >= 67 && n < 67 + N) begin
            k = n - 67;                   // R5: single bubble away from edge
            f = k; kind = 2;
            if (k % 2 == 0 && k >= 3)          g = (k * 7) % (k - 2);
            else if (k % 2 == 1 && k <= N - 3) g = k + 2 + (k * 5) % (N - 2 - k);
        end else if (n >= 65533 && n < 65539) begin
            f = 10 + n % 7; kind = 3;     // R8: across wrap-around
        end
    endfunction

    function automatic string tag_of(input int kind);
        case (kind)
            1:       return "R4,R9,R3";
            2:       return "R5";
            3:       return "R8,R2";
            default: return "R6";
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        int f, g, kind, per, ri;
        logic [N-1:0] p;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(v == 1'b0, "R1 valid", int'(v), 0);
        chk(coarse == '0, "R1 coarse", int'(coarse), 0);
        chk(fine == '0, "R1 fine", int'(fine), 0);
        rst_n = 1'b1;
        for (int n = 0; n <= NLAST; n++) begin
            if (n > 0) @(negedge clk);
            // build period n
            sched(n, f, g, kind);
            p = '0;
            for (int i = 0; i < N; i++) if (i < f) p[i] = 1'b1;
            if (g >= 0) p[g] = ~p[g];
            pat_r[n % 8]  = p;
            fexp_r[n % 8] = f;
            kind_r[n % 8] = kind;
            // drive with per-section skew (R3); pre-reset periods all-zero
            for (int s = 0; s < NSEC; s++) begin
                if (n - s < 0) taps[s*TAPS +: TAPS] = '0;
                else           taps[s*TAPS +: TAPS] = pat_r[(n - s) % 8][s*TAPS +: TAPS];
            end
            // outputs now reflect edge n-1, i.e. period n-1-NSEC (R7)
            if (n >= 1) begin
                per = n - 1 - NSEC;
                if (per < 0) begin
                    chk(v == 1'b0, "R10 fill", int'(v), 0);
                end else begin
                    ri = per % 8;
                    chk(v == (fexp_r[ri] < N), {tag_of(kind_r[ri]), ",R7 valid"},
                        int'(v), int'(fexp_r[ri] < N));
                    if (v && fexp_r[ri] < N) begin
                        chk(coarse == CW'(per), {tag_of(kind_r[ri]), " coarse"},
                            int'(coarse), per % 65536);
                        chk(int'(fine) == fexp_r[ri], {tag_of(kind_r[ri]), " fine"},
                            int'(fine), fexp_r[ri]);
                    end
                end
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule